// File: doc/BRIEF.md
# Trace address XOR compressor

This block shrinks the instruction addresses carried by a branch trace stream. It keeps a reference register holding the last address it emitted. Each new execution address is XORed with that reference. Only the low bits that hold the difference are reported, together with the length of that field.

Bit 0 is never sent, because instruction addresses are always halfword aligned. Every field therefore starts at address bit 1. The whole address is sent instead of a difference in three cases: when there is no reference yet, when the caller asks for a full address (for example at a sync point), or while the global no-difference mode is on.

The result appears one cycle after the input strobe. A downstream packer uses the field value, its length and the full/relative flag to build messages.

Top module: `tac_compressor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_vld`, `out_field`, `out_len` and `out_is_full` are all zero.
- R2: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high. Each input strobe yields exactly one result.
- R3: The first address accepted after reset is emitted as a full address: `out_is_full`=1, `out_field` = address bits [ADDR_W-1:1], and `out_len` = ADDR_W-1. For example, 0x3FC04 gives field 0x1FE02 and length 31.
- R4: Otherwise an address is emitted relative to the reference: `out_is_full`=0 and `out_field` = (address XOR reference) >> 1. Reference 0x3FC04 with address 0x3F368 gives 0x7B6. Reference 0x3F368 with address 0x3E100 gives 0x934.
- R5: The length of a relative field is one plus the index of the highest set bit of the field. A field of zero has length 1. For example, 0x7B6 has length 11, 0x934 has length 12 and 0x1 has length 1.
- R6: After every emitted field, full or relative, the reference holds the address that was just emitted.
- R7: An accepted address with `in_full_req`=1 is emitted as a full address, as in R3, even when a reference exists.
- R8: While `no_diff_mode`=1, every accepted address is emitted as a full address.
- R9: Cycles with `in_vld`=0 leave the reference unchanged, whatever value `in_addr` carries in those cycles.
- R10: Address bit 0 has no effect. Two addresses that differ only in bit 0 give a relative field of 0 with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | An address is presented this cycle |
| in_addr | input | ADDR_W | Execution address |
| in_full_req | input | 1 | Emit this address in full |
| no_diff_mode | input | 1 | Global mode: always emit full addresses |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_field | output | ADDR_W-1 | Full address bits [ADDR_W-1:1] or shifted XOR difference |
| out_len | output | $clog2(ADDR_W) | Significant bit count of `out_field` |
| out_is_full | output | 1 | 1 = full field, 0 = relative field |

## Verification
The hardest case to reach from the ports is a reference that has to survive idle cycles while `in_addr` changes underneath it. The stimulus holds `in_vld` low, moves `in_addr` to an unrelated value, and then checks the next relative field against the address sent before the gap.

The opposite extreme also needs care: a difference in the top address bit, which must give a relative field as long as a full one while still being marked relative. The stimulus reaches it by sending a forced-full address of 0x80000000 followed by address 0. A reset in the middle of a stream confirms that the reference is dropped and the next address is sent in full.

// File: rtl/tac_pkg.sv
package tac_pkg;
  // Significant length of a value: index of its top set bit plus one,
  // with a zero value reported as length one.
  function automatic logic [6:0] tac_sig_len(input logic [63:0] v);
    logic [6:0] r;
    r = 7'd1;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) r = 7'(i + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/tac_ref_store.sv
module tac_ref_store #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] ref_addr,
  output logic              ref_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr <= '0;
      ref_ok   <= 1'b0;
    end else if (take) begin
      ref_addr <= addr;
      ref_ok   <= 1'b1;
    end
  end
endmodule

// File: rtl/tac_diff.sv
module tac_diff
  import tac_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int FW = ADDR_W - 1,
  localparam int LW = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              ref_ok,
  input  logic              full_req,
  input  logic              no_diff,
  output logic [FW-1:0]     field,
  output logic [LW-1:0]     len,
  output logic              send_full
);
  logic [ADDR_W-1:0] diff;
  logic [FW-1:0]     rel_field;

  assign diff      = addr ^ ref_addr;
  assign rel_field = diff[ADDR_W-1:1];
  assign send_full = !ref_ok || full_req || no_diff;

  always_comb begin
    if (send_full) begin
      field = addr[ADDR_W-1:1];
      len   = LW'(FW);
    end else begin
      field = rel_field;
      len   = LW'(tac_sig_len(64'(rel_field)));
    end
  end
endmodule

// File: rtl/tac_out_reg.sv
module tac_out_reg #(
  parameter int FW = 31,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_d,
  input  logic [FW-1:0] field_d,
  input  logic [LW-1:0] len_d,
  input  logic          full_d,
  output logic          vld_q,
  output logic [FW-1:0] field_q,
  output logic [LW-1:0] len_q,
  output logic          full_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      field_q <= '0;
      len_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (vld_d) begin
        field_q <= field_d;
        len_q   <= len_d;
        full_q  <= full_d;
      end
    end
  end
endmodule

// File: rtl/tac_compressor.sv
module tac_compressor #(
  parameter int ADDR_W = 32,
  localparam int FW = ADDR_W - 1,
  localparam int LW = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_full_req,
  input  logic              no_diff_mode,
  output logic              out_vld,
  output logic [FW-1:0]     out_field,
  output logic [LW-1:0]     out_len,
  output logic              out_is_full
);
  logic [ADDR_W-1:0] ref_addr;
  logic              ref_ok;
  logic [FW-1:0]     nxt_field;
  logic [LW-1:0]     nxt_len;
  logic              nxt_full;

  tac_ref_store #(.ADDR_W(ADDR_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .take(in_vld), .addr(in_addr),
    .ref_addr(ref_addr), .ref_ok(ref_ok)
  );

  tac_diff #(.ADDR_W(ADDR_W)) u_diff (
    .addr(in_addr), .ref_addr(ref_addr), .ref_ok(ref_ok),
    .full_req(in_full_req), .no_diff(no_diff_mode),
    .field(nxt_field), .len(nxt_len), .send_full(nxt_full)
  );

  tac_out_reg #(.FW(FW), .LW(LW)) u_out (
    .clk(clk), .rst_n(rst_n), .vld_d(in_vld), .field_d(nxt_field),
    .len_d(nxt_len), .full_d(nxt_full),
    .vld_q(out_vld), .field_q(out_field), .len_q(out_len), .full_q(out_is_full)
  );
endmodule

// File: rtl/tac_compressor_chk.sv
module tac_compressor_chk #(
  parameter int ADDR_W = 32,
  localparam int FW = ADDR_W - 1,
  localparam int LW = $clog2(ADDR_W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [FW-1:0] addr_hi,
  input logic          in_full_req,
  input logic          no_diff_mode,
  input logic          out_vld,
  input logic [FW-1:0] out_field,
  input logic [LW-1:0] out_len,
  input logic          out_is_full
);
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  a_r7_force_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_full_req) |=> out_is_full);
  a_r8_nodiff_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && no_diff_mode) |=> out_is_full);
  a_r3_full_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (!out_is_full || (out_field == $past(addr_hi) && out_len == LW'(FW))));
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_is_full) |-> (out_len != '0 && (out_field >> out_len) == '0));
endmodule

bind tac_compressor tac_compressor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .addr_hi(in_addr[ADDR_W-1:1]),
  .in_full_req(in_full_req), .no_diff_mode(no_diff_mode), .out_vld(out_vld),
  .out_field(out_field), .out_len(out_len), .out_is_full(out_is_full)
);

// File: tb/tac_compressor_test.sv
module tac_compressor_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NV = 10;

  // {addr, full_req, nodiff, exp_field, exp_len, exp_full}
  typedef struct packed {
    logic [31:0] addr;
    logic        fr;
    logic        nd;
    logic [30:0] ef;
    logic [4:0]  el;
    logic        efull;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0003FC04, 1'b0, 1'b0, 31'h1FE02,    5'd31, 1'b1},
    '{32'h0003F368, 1'b0, 1'b0, 31'h7B6,      5'd11, 1'b0},
    '{32'h0003E100, 1'b0, 1'b0, 31'h934,      5'd12, 1'b0},
    '{32'h0003E101, 1'b0, 1'b0, 31'h0,        5'd1,  1'b0},
    '{32'h0003E103, 1'b0, 1'b0, 31'h1,        5'd1,  1'b0},
    '{32'h0003E107, 1'b0, 1'b0, 31'h2,        5'd2,  1'b0},
    '{32'h80000000, 1'b1, 1'b0, 31'h40000000, 5'd31, 1'b1},
    '{32'h00000000, 1'b0, 1'b0, 31'h40000000, 5'd31, 1'b0},
    '{32'h00001234, 1'b0, 1'b1, 31'h91A,      5'd31, 1'b1},
    '{32'h00001236, 1'b0, 1'b0, 31'h1,        5'd1,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic in_full_req = 1'b0;
  logic no_diff_mode = 1'b0;
  logic out_vld;
  logic [AW-2:0] out_field;
  logic [4:0] out_len;
  logic out_is_full;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tac_compressor #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_addr(in_addr),
    .in_full_req(in_full_req), .no_diff_mode(no_diff_mode),
    .out_vld(out_vld), .out_field(out_field), .out_len(out_len),
    .out_is_full(out_is_full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [AW-1:0] a, input logic fr, input logic nd);
    in_vld = v; in_addr = a; in_full_req = fr; no_diff_mode = nd;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [30:0] f, input logic [4:0] l, input logic full);
    chk(req, 64'(out_vld), 64'd1);
    chk(req, 64'(out_field), 64'(f));
    chk(req, 64'(out_len), 64'(l));
    chk(req, 64'(out_is_full), 64'(full));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk("R1 vld", 64'(out_vld), 0);
    chk("R1 field", 64'(out_field), 0);
    chk("R1 len", 64'(out_len), 0);
    chk("R1 full", 64'(out_is_full), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset vld", 64'(out_vld), 0);

    // Table walk, back-to-back strobes: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].addr, VECS[i].fr, VECS[i].nd);
      expect_out($sformatf("R3/R4/R5/R6/R7/R8/R10 vec%0d", i),
                 VECS[i].ef, VECS[i].el, VECS[i].efull);
    end

    // R2 and R9: idle gap with a changing address leaves the reference alone
    drive(1'b0, 32'hDEADBEEE, 1'b0, 1'b0);
    chk("R2 idle vld", 64'(out_vld), 0);
    drive(1'b0, 32'h0F0F0F0E, 1'b1, 1'b0);
    chk("R2 idle vld 2", 64'(out_vld), 0);
    drive(1'b1, 32'h00001232, 1'b0, 1'b0);
    expect_out("R9 ref kept", 31'h2, 5'd2, 1'b0);

    // R8: no-diff mode across consecutive addresses
    drive(1'b1, 32'h00001234, 1'b0, 1'b1);
    expect_out("R8 nd a", 31'h91A, 5'd31, 1'b1);
    drive(1'b1, 32'h00001236, 1'b0, 1'b1);
    expect_out("R8 nd b", 31'h91B, 5'd31, 1'b1);
    // R6: the reference followed the full sends
    drive(1'b1, 32'h0000123E, 1'b0, 1'b0);
    expect_out("R6 ref after full", 31'h4, 5'd3, 1'b0);

    // R3: reset mid-stream drops the reference
    in_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid vld", 64'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 32'h0000123C, 1'b0, 1'b0);
    expect_out("R3 first after reset", 31'h91E, 5'd31, 1'b1);
    drive(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R2 single strobe", 64'(out_vld), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule